// File: doc/BRIEF.md
# Oscillator Settling Wake-up Timer

This block keeps the CPU clock gate closed after a reset or after a wake from power-down, so that the CPU clock only starts once the selected oscillator has settled. The wait has two phases. First it counts a number of oscillator cycles, and that number depends on the kind of clock source. Then it waits a fixed settling time, measured in ticks of a slow, free-running microsecond timebase.

The block runs entirely in the oscillator clock domain. The microsecond tick comes from another domain, so it is synchronised first. When both phases have finished, the clock enable rises and stays high until the next wake request or reset. A one-cycle ready pulse marks the moment the enable rises. Any wake request, even one that arrives in the middle of a sequence, starts a new sequence from the beginning.

Top module: `wake_gate_timer`

## Requirements
- R1: Source codes 3'b000, 3'b001 and 3'b010 (the high, medium and low crystal ranges) make the cycle phase last XTAL_CYCLES oscillator edges (default 992).
- R2: Source codes 3'b011 (RC oscillator), 3'b100 (watchdog oscillator) and 3'b101 (external clock) make the cycle phase last FAST_CYCLES oscillator edges (default 224).
- R3: The unused codes 3'b110 and 3'b111 are treated as an external clock, so the cycle phase lasts FAST_CYCLES edges.
- R4: The settling phase follows the cycle phase. It counts rising edges of `us_tick`, taken after a SYNC_STAGES-flop synchroniser, and only rises seen after the cycle phase count. The number of rises counted is SETTLE_TICKS clamped to the range 60..100 (default 80).
- R5: `cpu_clk_en` stays low for the whole sequence and rises on the edge that counts the last settling tick. A tick that is first sampled high at edge k is counted at edge k+2.
- R6: `ready_pulse` is high for exactly one oscillator cycle: the first cycle in which `cpu_clk_en` is high.
- R7: Once high, `cpu_clk_en` stays high until a wake request or a reset.
- R8: `src_sel` is sampled on the wake edge, or on the first edge after reset is released. Changes to it during a sequence have no effect on that sequence's timing.
- R9: A wake request at any time, including during a sequence, drops the enable and restarts the sequence with both counters cleared.
- R10: An asserted `arst_n` (active low) forces `cpu_clk_en` and `ready_pulse` low at once. A new sequence starts when the reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock |
| arst_n | input | 1 | Asynchronous reset, active low |
| wake_req | input | 1 | Power-down exit request; each high cycle restarts the sequence |
| src_sel | input | 3 | Clock-source code |
| us_tick | input | 1 | Free-running microsecond tick from a slow timebase (asynchronous) |
| cpu_clk_en | output | 1 | Enable for the CPU clock gate |
| ready_pulse | output | 1 | One-cycle pulse when the enable rises |

## Verification
The bench builds two instances from the same stimulus. One uses the default cycle counts of 992 and 224 and 80 settling ticks. The other sets SETTLE_TICKS to 20, which is below the allowed window, so the bench can check that it settles after 60 ticks. The tick repeats every 10 oscillator cycles and stays high for two of them, so a full long sequence finishes in under two thousand cycles. The bench predicts the exact edge on which the enable rises, including ticks that arrive just before the cycle phase ends, for every source code, for a select change mid-sequence, for a restart during the settling phase, and for a reset in the middle of a sequence.

// File: rtl/wkt_pkg.sv
package wkt_pkg;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_CYC  = 2'd1,
    ST_TIME = 2'd2,
    ST_DONE = 2'd3
  } wkt_state_e;

  localparam logic [2:0] SRC_XTAL_HI  = 3'b000;
  localparam logic [2:0] SRC_XTAL_MID = 3'b001;
  localparam logic [2:0] SRC_XTAL_LO  = 3'b010;

  localparam int unsigned TICK_FLOOR = 60;
  localparam int unsigned TICK_CEIL  = 100;

  // Crystal codes take the long count; every other code takes the short one.
  function automatic int unsigned cycles_for_source(input logic [2:0] sel,
                                                    input int unsigned xtal_n,
                                                    input int unsigned fast_n);
    int unsigned r;
    case (sel)
      SRC_XTAL_HI, SRC_XTAL_MID, SRC_XTAL_LO: r = xtal_n;
      default:                                r = fast_n;
    endcase
    return r;
  endfunction

  // Keep the settling tick count inside the permitted window.
  function automatic int unsigned settle_ticks_eff(input int unsigned n);
    int unsigned r;
    if (n < TICK_FLOOR)      r = TICK_FLOOR;
    else if (n > TICK_CEIL)  r = TICK_CEIL;
    else                     r = n;
    return r;
  endfunction

endpackage

// File: rtl/wkt_tick_sync.sv
module wkt_tick_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic tick_in,
  output logic rise_o
);
  localparam int unsigned NS = (STAGES < 2) ? 2 : STAGES;

  logic [NS-1:0] sh_q;
  logic          last_q;

  genvar gi;
  generate
    for (gi = 0; gi < NS; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) sh_q[0] <= 1'b0;
          else         sh_q[0] <= tick_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) sh_q[gi] <= 1'b0;
          else         sh_q[gi] <= sh_q[gi-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) last_q <= 1'b0;
    else         last_q <= sh_q[NS-1];
  end

  assign rise_o = sh_q[NS-1] & ~last_q;
endmodule

// File: rtl/wkt_counter.sv
module wkt_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic         clr,
  input  logic         inc,
  input  logic [W-1:0] last,
  output logic         hit_o
);
  logic [W-1:0] cnt_q;

  assign hit_o = inc && !clr && (cnt_q == last);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)            cnt_q <= '0;
    else if (clr || hit_o)  cnt_q <= '0;
    else if (inc)           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wkt_fsm.sv
module wkt_fsm
  import wkt_pkg::*;
(
  input  logic       clk,
  input  logic       arst_n,
  input  logic       wake,
  input  logic       cyc_hit,
  input  logic       time_hit,
  output wkt_state_e st_o
);
  wkt_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (wake) begin
      st_d = ST_CYC;
    end else begin
      case (st_q)
        ST_CYC:  if (cyc_hit)  st_d = ST_TIME;
        ST_TIME: if (time_hit) st_d = ST_DONE;
        ST_DONE: st_d = ST_RUN;
        default: st_d = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) st_q <= ST_CYC;
    else         st_q <= st_d;
  end

  assign st_o = st_q;
endmodule

// File: rtl/wake_gate_timer.sv
module wake_gate_timer
  import wkt_pkg::*;
#(
  parameter int unsigned XTAL_CYCLES  = 992,
  parameter int unsigned FAST_CYCLES  = 224,
  parameter int unsigned SETTLE_TICKS = 80,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic       clk_osc,
  input  logic       arst_n,
  input  logic       wake_req,
  input  logic [2:0] src_sel,
  input  logic       us_tick,
  output logic       cpu_clk_en,
  output logic       ready_pulse
);
  localparam int unsigned CYC_MAX   = (XTAL_CYCLES > FAST_CYCLES) ? XTAL_CYCLES : FAST_CYCLES;
  localparam int unsigned CYC_W     = $clog2(CYC_MAX + 1);
  localparam int unsigned TICKS_EFF = settle_ticks_eff(SETTLE_TICKS);
  localparam int unsigned TIME_W    = $clog2(TICK_CEIL + 1);

  // Named internal events, also observed by the bound checker.
  wkt_state_e        st;
  logic              tick_rise;
  logic              cyc_hit;
  logic              time_hit;
  logic              first_q;
  logic [2:0]        sel_q;
  logic [2:0]        eff_sel;
  logic [CYC_W-1:0]  cyc_last;
  logic [TIME_W-1:0] time_last;

  // Select capture: first edge after reset, or the wake edge.
  always_ff @(posedge clk_osc or negedge arst_n) begin
    if (!arst_n) begin
      sel_q   <= SRC_XTAL_HI;
      first_q <= 1'b1;
    end else begin
      if (first_q || wake_req) sel_q <= src_sel;
      first_q <= 1'b0;
    end
  end

  assign eff_sel   = first_q ? src_sel : sel_q;
  assign cyc_last  = CYC_W'(cycles_for_source(eff_sel, XTAL_CYCLES, FAST_CYCLES) - 1);
  assign time_last = TIME_W'(TICKS_EFF - 1);

  wkt_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk_osc),
    .arst_n  (arst_n),
    .tick_in (us_tick),
    .rise_o  (tick_rise)
  );

  wkt_counter #(.W(CYC_W)) u_cyc_cnt (
    .clk    (clk_osc),
    .arst_n (arst_n),
    .clr    (wake_req || (st != ST_CYC)),
    .inc    (st == ST_CYC),
    .last   (cyc_last),
    .hit_o  (cyc_hit)
  );

  wkt_counter #(.W(TIME_W)) u_time_cnt (
    .clk    (clk_osc),
    .arst_n (arst_n),
    .clr    (wake_req || (st != ST_TIME)),
    .inc    ((st == ST_TIME) && tick_rise),
    .last   (time_last),
    .hit_o  (time_hit)
  );

  wkt_fsm u_fsm (
    .clk      (clk_osc),
    .arst_n   (arst_n),
    .wake     (wake_req),
    .cyc_hit  (cyc_hit),
    .time_hit (time_hit),
    .st_o     (st)
  );

  assign cpu_clk_en  = (st == ST_RUN) || (st == ST_DONE);
  assign ready_pulse = (st == ST_DONE);
endmodule

// File: rtl/wkt_checker.sv
module wkt_checker (
  input logic       clk_osc,
  input logic       arst_n,
  input logic       wake_req,
  input logic       cpu_clk_en,
  input logic       ready_pulse,
  input logic       time_hit,
  input logic       first_q,
  input logic [2:0] sel_q
);
  // R5: enable only rises after the final settling tick was counted
  assert_en_after_settle_R5: assert property (@(posedge clk_osc) disable iff (!arst_n)
    $rose(cpu_clk_en) |-> $past(time_hit));

  // R6: ready is a single-cycle pulse
  assert_ready_single_R6: assert property (@(posedge clk_osc) disable iff (!arst_n)
    ready_pulse |=> !ready_pulse);

  // R6: every enable rise carries the ready pulse
  assert_ready_on_rise_R6: assert property (@(posedge clk_osc) disable iff (!arst_n)
    $rose(cpu_clk_en) |-> ready_pulse);

  // R7: enable holds until a wake request
  assert_en_hold_R7: assert property (@(posedge clk_osc) disable iff (!arst_n)
    (cpu_clk_en && !wake_req) |=> cpu_clk_en);

  // R9: a wake request closes the gate on the next cycle
  assert_wake_gates_R9: assert property (@(posedge clk_osc) disable iff (!arst_n)
    wake_req |=> !cpu_clk_en);

  // R8: captured select frozen during a sequence
  assert_sel_frozen_R8: assert property (@(posedge clk_osc) disable iff (!arst_n)
    (!cpu_clk_en && !wake_req && !first_q) |=> $stable(sel_q));
endmodule

bind wake_gate_timer wkt_checker chk_i (
  .clk_osc     (clk_osc),
  .arst_n      (arst_n),
  .wake_req    (wake_req),
  .cpu_clk_en  (cpu_clk_en),
  .ready_pulse (ready_pulse),
  .time_hit    (time_hit),
  .first_q     (first_q),
  .sel_q       (sel_q)
);

// File: tb/wake_gate_timer_tb.sv
module wake_gate_timer_tb_top;
  localparam int TP   = 10;   // tick period in oscillator cycles
  localparam int XC   = 992;
  localparam int FC   = 224;
  localparam int N_A  = 80;   // default settling ticks
  localparam int N_B  = 60;   // SETTLE_TICKS=20 clamped up

  logic       clk = 1'b0;
  logic       arst_n;
  logic       wake_req;
  logic [2:0] src_sel;
  logic       us_tick;
  logic       en_a, rdy_a, en_b, rdy_b;

  always #10 clk = ~clk;

  wake_gate_timer dut_i (
    .clk_osc(clk), .arst_n(arst_n), .wake_req(wake_req), .src_sel(src_sel),
    .us_tick(us_tick), .cpu_clk_en(en_a), .ready_pulse(rdy_a));

  wake_gate_timer #(.SETTLE_TICKS(20)) dut_lo_i (
    .clk_osc(clk), .arst_n(arst_n), .wake_req(wake_req), .src_sel(src_sel),
    .us_tick(us_tick), .cpu_clk_en(en_b), .ready_pulse(rdy_b));

  typedef struct {
    int    ta;
    int    tb;
    string what;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   in_rst = 1'b1;
  bit   finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // tick: high at edges whose number is 0 or 1 modulo TP
  initial begin
    us_tick = 1'b0;
    forever begin
      @(negedge clk);
      us_tick = (((cyc + 1) % TP) == 0) || (((cyc + 1) % TP) == 1);
    end
  end

  function automatic int src_cycles(input logic [2:0] s);
    return (s <= 3'd2) ? XC : FC;
  endfunction

  // Edge at which the enable rises, sequence started at edge s.
  function automatic int exp_edge(input int s, input int c, input int n);
    int k = s + c - 1;
    while ((k % TP) != 0) k++;
    return k + 2 + (n - 1) * TP;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", req, what, cyc, act, expv);
    end
  endtask

  task automatic push(input int s, input logic [2:0] sel, input string what);
    exp_t e;
    e.ta   = exp_edge(s, src_cycles(sel), N_A);
    e.tb   = exp_edge(s, src_cycles(sel), N_B);
    e.what = what;
    q.push_back(e);
  endtask

  // Monitor: compare outputs against the queued expectation
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (in_rst) begin
        chk(en_a == 1'b0 && en_b == 1'b0, "R10", "enable in reset", int'(en_a), 0);
        chk(rdy_a == 1'b0 && rdy_b == 1'b0, "R10", "ready in reset", int'(rdy_a), 0);
      end else if (q.size() > 0) begin
        chk(en_a == (cyc >= q[0].ta), "R5", q[0].what, int'(en_a), int'(cyc >= q[0].ta));
        chk(rdy_a == (cyc == q[0].ta), "R6", q[0].what, int'(rdy_a), int'(cyc == q[0].ta));
        chk(en_b == (cyc >= q[0].tb), "R4", {"clamped ", q[0].what}, int'(en_b), int'(cyc >= q[0].tb));
        chk(rdy_b == (cyc == q[0].tb), "R6", {"clamped ", q[0].what}, int'(rdy_b), int'(cyc == q[0].tb));
        if (cyc > q[0].ta && cyc > q[0].tb) void'(q.pop_front());
      end else begin
        chk(en_a && en_b, "R7", "enable held", int'(en_a & en_b), 1);
        chk(!rdy_a && !rdy_b, "R7", "no ready while held", int'(rdy_a | rdy_b), 0);
      end
    end
  end

  task automatic do_reset(input logic [2:0] s, input int hold, input string what);
    @(negedge clk);
    arst_n = 1'b0;
    in_rst = 1'b1;
    q.delete();
    src_sel = s;
    repeat (hold) @(negedge clk);
    arst_n = 1'b1;
    in_rst = 1'b0;
    push(cyc, s, what);
  endtask

  task automatic do_wake(input logic [2:0] s, input string what);
    @(negedge clk);
    src_sel  = s;
    wake_req = 1'b1;
    @(negedge clk);
    wake_req = 1'b0;
    q.delete();
    push(cyc, s, what);
  endtask

  task automatic wait_done();
    while (q.size() != 0) @(negedge clk);
    repeat (20) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    wait (cyc >= 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
    summary();
  end

  initial begin
    arst_n   = 1'b0;
    wake_req = 1'b0;
    src_sel  = 3'b000;
    repeat (4) @(negedge clk);
    do_reset(3'b000, 3, "R1 R10 reset high crystal");
    wait_done();
    do_wake(3'b001, "R1 medium crystal");  wait_done();
    do_wake(3'b010, "R1 low crystal");     wait_done();
    do_wake(3'b011, "R2 RC oscillator");   wait_done();
    do_wake(3'b100, "R2 watchdog osc");    wait_done();
    do_wake(3'b101, "R2 external clock");  wait_done();
    do_wake(3'b110, "R3 code 110");        wait_done();
    do_wake(3'b111, "R3 code 111");        wait_done();
    // R8: select changes mid-sequence to a crystal code; short count must remain
    do_wake(3'b011, "R8 select change ignored");
    repeat (50) @(negedge clk);
    src_sel = 3'b000;
    wait_done();
    // R9: restart during the settling phase with a new source
    do_wake(3'b000, "R9 first sequence");
    repeat (1100) @(negedge clk);
    do_wake(3'b100, "R9 restarted sequence");
    wait_done();
    // R10: reset in the middle of a sequence, restart with select 010
    do_wake(3'b101, "R10 interrupted sequence");
    repeat (300) @(negedge clk);
    do_reset(3'b010, 5, "R10 reset mid-sequence");
    wait_done();
    // R7: enable holds for a long idle stretch
    repeat (400) @(negedge clk);
    summary();
  end
endmodule